// File: doc/BRIEF.md
# Nibble Accumulator Datapath with Carry

This block is the 4-bit working-register slice of a small controller core. It holds an accumulator, a 4-bit scratch register, an 8-bit extension register and a carry bit. A decoder outside the block presents one encoded micro-operation per strobe, together with a memory nibble and an immediate nibble. The block performs that operation on the next rising clock edge.

Two kinds of addition share one adder. Only the carry-in form writes the carry bit. The other two additions wrap silently and leave the carry as it was. A right rotation moves bits through the carry. Two operations set or clear the carry directly. Transfer operations move data between the accumulator and the scratch register. They also join the scratch register (upper nibble) and the accumulator (lower nibble) into the 8-bit register, or split that register back into them. A compare-immediate operation raises a skip flag for exactly one cycle when it finds equality. The sequencer uses this flag to skip the following instruction.

The extension register has no reset. Software must write it before it reads it.

Top module: `nacc_core`

## Requirements
- R1: When `op_stb` is low, `acc_a`, `reg_b`, `reg_e` and `carry` keep their values, whatever `op_sel` holds.
- R2: Code 1 (add memory with carry) writes (A + M + CY) mod 16 to A and the carry out of that sum to CY. Example: F + F + 1 gives A = F and CY = 1.
- R3: Code 2 (add immediate) writes (A + imm) mod 16 to A. Code 3 (add memory) writes (A + M) mod 16 to A. Neither changes CY.
- R4: Code 4 (rotate right through carry) loads the old A[0] into CY and shifts A[3:1] into A[2:0]. The old CY goes into A[3].
- R5: Code 5 forces CY to 1. Code 6 forces CY to 0. A and B do not change.
- R6: Code 7 copies A into B. Code 8 copies B into A.
- R7: Code 9 loads E with {B, A}, with B in bits 7..4. Code 10 loads B from E[7:4] and A from E[3:0].
- R8: Code 11 (compare immediate) drives `skip` high for the single following cycle when A equals imm, and low otherwise. A and CY do not change.
- R9: While reset is active, A, B, CY and `skip` are 0. Reset does not change E.
- R10: Code 0 and the unused codes 12 to 15 change no register and leave `skip` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_stb | input | 1 | Performs `op_sel` on this edge |
| op_sel | input | 4 | Encoded micro-operation |
| mem_opd | input | 4 | Memory operand nibble |
| imm | input | 4 | Immediate operand nibble |
| acc_a | output | 4 | Accumulator |
| reg_b | output | 4 | Scratch register |
| reg_e | output | 8 | Extension register |
| carry | output | 1 | Carry flag |
| skip | output | 1 | One-cycle compare-equal pulse |

## Verification
The hardest state to reach is a carry-in addition that overflows with every input at its maximum. Getting there needs A = F and CY = 1 together with a memory operand of F. The stimulus builds this state in three steps. It first loads F into A through a copy from B and an immediate add, which cannot touch the carry. It then sets the carry. It then issues the add.

The second point needing care is E after a mid-run reset. E holds a value only after a join operation, so the bench joins B and A into E before it pulses reset. It then observes E directly at the port.

// File: rtl/nacc_pkg.sv
package nacc_pkg;
    parameter int unsigned NIB_W = 4;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_ADDMC = 4'd1,
        OP_ADDI  = 4'd2,
        OP_ADDM  = 4'd3,
        OP_ROTR  = 4'd4,
        OP_SETC  = 4'd5,
        OP_CLRC  = 4'd6,
        OP_A2B   = 4'd7,
        OP_B2A   = 4'd8,
        OP_JOINE = 4'd9,
        OP_SPLTE = 4'd10,
        OP_CMPI  = 4'd11
    } nacc_op_e;
endpackage

// File: rtl/nacc_alu.sv
module nacc_alu
    import nacc_pkg::*;
#(
    parameter int unsigned W = NIB_W
) (
    input  nacc_op_e     op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] mem,
    input  logic [W-1:0] imm,
    input  logic         cy,
    output logic [W-1:0] sum,
    output logic         co,
    output logic [W-1:0] rot,
    output logic         eq
);
    localparam int unsigned SW = W + 1;

    logic [W-1:0]  opd;
    logic          cin;
    logic [SW-1:0] wide;

    // One shared adder: the operand is selected by op, and carry-in is used only by add-with-carry
    always_comb begin
        opd  = (op == OP_ADDI) ? imm : mem;
        cin  = (op == OP_ADDMC) & cy;
        wide = {1'b0, a} + {1'b0, opd} + {{W{1'b0}}, cin};
        sum  = wide[W-1:0];
        co   = wide[W];
        rot  = {cy, a[W-1:1]};
        eq   = (a == imm);
    end
endmodule

// File: rtl/nacc_carry.sv
module nacc_carry
    import nacc_pkg::*;
(
    input  nacc_op_e op,
    input  logic     go,
    input  logic     cy_q,
    input  logic     add_co,
    input  logic     a_lsb,
    output logic     cy_d
);
    always_comb begin
        cy_d = cy_q;
        if (go) begin
            case (op)
                OP_ADDMC: cy_d = add_co;
                OP_ROTR:  cy_d = a_lsb;
                OP_SETC:  cy_d = 1'b1;
                OP_CLRC:  cy_d = 1'b0;
                default:  cy_d = cy_q;
            endcase
        end
    end
endmodule

// File: rtl/nacc_core.sv
module nacc_core
    import nacc_pkg::*;
#(
    parameter int unsigned W = NIB_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           op_stb,
    input  logic [3:0]     op_sel,
    input  logic [W-1:0]   mem_opd,
    input  logic [W-1:0]   imm,
    output logic [W-1:0]   acc_a,
    output logic [W-1:0]   reg_b,
    output logic [2*W-1:0] reg_e,
    output logic           carry,
    output logic           skip
);
    localparam int unsigned EW = 2 * W;

    typedef struct packed {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic         cy;
        logic         skip;
    } core_t;

    core_t          st_q, st_d;
    logic [EW-1:0]  e_q, e_d;
    nacc_op_e       op;
    logic [W-1:0]   alu_sum, alu_rot;
    logic           alu_co, alu_eq, cy_nx;

    assign op = nacc_op_e'(op_sel);

    nacc_alu #(.W(W)) u_alu (
        .op  (op),
        .a   (st_q.a),
        .mem (mem_opd),
        .imm (imm),
        .cy  (st_q.cy),
        .sum (alu_sum),
        .co  (alu_co),
        .rot (alu_rot),
        .eq  (alu_eq)
    );

    nacc_carry u_carry (
        .op     (op),
        .go     (op_stb),
        .cy_q   (st_q.cy),
        .add_co (alu_co),
        .a_lsb  (st_q.a[0]),
        .cy_d   (cy_nx)
    );

    always_comb begin
        st_d      = st_q;
        st_d.cy   = cy_nx;
        st_d.skip = 1'b0;
        e_d       = e_q;
        if (op_stb) begin
            case (op)
                OP_ADDMC, OP_ADDI, OP_ADDM: st_d.a = alu_sum;
                OP_ROTR:  st_d.a = alu_rot;
                OP_A2B:   st_d.b = st_q.a;
                OP_B2A:   st_d.a = st_q.b;
                OP_JOINE: e_d    = {st_q.b, st_q.a};
                OP_SPLTE: begin
                    st_d.b = e_q[EW-1:W];
                    st_d.a = e_q[W-1:0];
                end
                OP_CMPI:  st_d.skip = alu_eq;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Extension register deliberately carries no reset
    always_ff @(posedge clk) begin
        e_q <= e_d;
    end

    assign acc_a = st_q.a;
    assign reg_b = st_q.b;
    assign reg_e = e_q;
    assign carry = st_q.cy;
    assign skip  = st_q.skip;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !op_stb |=> ($stable(acc_a) && $stable(reg_b) && $stable(carry))); // R1
    AST_ADDC_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (op_stb && op_sel == OP_ADDMC) |=>
        ({carry, acc_a} == {1'b0, $past(acc_a)} + {1'b0, $past(mem_opd)} + {{W{1'b0}}, $past(carry)})); // R2
    AST_ADD_KEEPS_CY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_stb && (op_sel == OP_ADDI || op_sel == OP_ADDM)) |=> $stable(carry)); // R3
    AST_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_stb && op_sel == OP_ROTR) |=>
        (carry == $past(acc_a[0]) && acc_a == {$past(carry), $past(acc_a[W-1:1])})); // R4
    AST_SET_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (op_stb && (op_sel == OP_SETC || op_sel == OP_CLRC)) |=>
        (carry == ($past(op_sel) == OP_SETC) && $stable(acc_a))); // R5
    AST_JOIN_E: assert property (@(posedge clk) disable iff (!rst_n)
        (op_stb && op_sel == OP_JOINE) |=> (reg_e == {$past(reg_b), $past(acc_a)})); // R7
    AST_SKIP_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        skip |-> ($past(op_stb) && $past(op_sel) == OP_CMPI && $past(acc_a) == $past(imm))); // R8
    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_stb && op_sel == OP_CMPI) |=> ($stable(acc_a) && $stable(carry))); // R8
    AST_UNUSED_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_stb && (op_sel == OP_NOP || op_sel > OP_CMPI)) |=>
        ($stable(acc_a) && $stable(reg_b) && $stable(carry) && !skip)); // R10
endmodule

// File: tb/nacc_core_bench.sv
module nacc_core_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_stb = 1'b0;
    logic [3:0] op_sel = 4'd0;
    logic [3:0] mem_opd = 4'd0;
    logic [3:0] imm = 4'd0;
    logic [3:0] acc_a, reg_b;
    logic [7:0] reg_e;
    logic       carry, skip;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    nacc_core u_nacc_core (
        .clk(clk), .rst_n(rst_n), .op_stb(op_stb), .op_sel(op_sel),
        .mem_opd(mem_opd), .imm(imm), .acc_a(acc_a), .reg_b(reg_b),
        .reg_e(reg_e), .carry(carry), .skip(skip)
    );

    typedef struct packed {
        logic [3:0] op;
        logic [3:0] m;
        logic [3:0] im;
        logic [3:0] a;
        logic [3:0] b;
        logic [7:0] e;
        logic       cy;
        logic       sk;
        logic       ce;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{4'd2,  4'h0, 4'h5, 4'h5, 4'h0, 8'h00, 1'b0, 1'b0, 1'b0},
        '{4'd1,  4'hC, 4'h0, 4'h1, 4'h0, 8'h00, 1'b1, 1'b0, 1'b0},
        '{4'd2,  4'h0, 4'hF, 4'h0, 4'h0, 8'h00, 1'b1, 1'b0, 1'b0},
        '{4'd1,  4'h3, 4'h0, 4'h4, 4'h0, 8'h00, 1'b0, 1'b0, 1'b0},
        '{4'd3,  4'hE, 4'h0, 4'h2, 4'h0, 8'h00, 1'b0, 1'b0, 1'b0},
        '{4'd5,  4'h0, 4'h0, 4'h2, 4'h0, 8'h00, 1'b1, 1'b0, 1'b0},
        '{4'd4,  4'h0, 4'h0, 4'h9, 4'h0, 8'h00, 1'b0, 1'b0, 1'b0},
        '{4'd4,  4'h0, 4'h0, 4'h4, 4'h0, 8'h00, 1'b1, 1'b0, 1'b0},
        '{4'd7,  4'h0, 4'h0, 4'h4, 4'h4, 8'h00, 1'b1, 1'b0, 1'b0},
        '{4'd2,  4'h0, 4'h7, 4'hB, 4'h4, 8'h00, 1'b1, 1'b0, 1'b0},
        '{4'd9,  4'h0, 4'h0, 4'hB, 4'h4, 8'h4B, 1'b1, 1'b0, 1'b1},
        '{4'd6,  4'h0, 4'h0, 4'hB, 4'h4, 8'h4B, 1'b0, 1'b0, 1'b1},
        '{4'd8,  4'h0, 4'h0, 4'h4, 4'h4, 8'h4B, 1'b0, 1'b0, 1'b1},
        '{4'd11, 4'h0, 4'h4, 4'h4, 4'h4, 8'h4B, 1'b0, 1'b1, 1'b1},
        '{4'd11, 4'h0, 4'h5, 4'h4, 4'h4, 8'h4B, 1'b0, 1'b0, 1'b1},
        '{4'd10, 4'h0, 4'h0, 4'hB, 4'h4, 8'h4B, 1'b0, 1'b0, 1'b1},
        '{4'd0,  4'hF, 4'hF, 4'hB, 4'h4, 8'h4B, 1'b0, 1'b0, 1'b1},
        '{4'd15, 4'hF, 4'hF, 4'hB, 4'h4, 8'h4B, 1'b0, 1'b0, 1'b1}
    };

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd1:        return "R2";
            4'd2, 4'd3:  return "R3";
            4'd4:        return "R4";
            4'd5, 4'd6:  return "R5";
            4'd7, 4'd8:  return "R6";
            4'd9, 4'd10: return "R7";
            4'd11:       return "R8";
            default:     return "R10";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_state(input string req, input logic [3:0] a, input logic [3:0] b,
                             input logic cy, input logic sk);
        chk(req, "state", {acc_a, reg_b} , {a, b});
        chk(req, "cy/skip", {6'd0, carry, skip}, {6'd0, cy, sk});
    endtask

    // Drive at a falling edge, let one rising edge act, sample at the next falling edge
    task automatic issue(input logic [3:0] op, input logic [3:0] m, input logic [3:0] im, input logic stb);
        op_sel = op; mem_opd = m; imm = im; op_stb = stb;
        @(negedge clk);
        op_stb = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_state("R9", 4'h0, 4'h0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].op, VECS[i].m, VECS[i].im, 1'b1);
            chk_state(req_of(VECS[i].op), VECS[i].a, VECS[i].b, VECS[i].cy, VECS[i].sk);
            if (VECS[i].ce) chk(req_of(VECS[i].op), "reg_e", reg_e, VECS[i].e);
        end

        // R1: strobe low, operations presented but ignored (A=B, B=4, CY=0)
        issue(4'd2, 4'h0, 4'h3, 1'b0);
        issue(4'd5, 4'h0, 4'h0, 1'b0);
        issue(4'd9, 4'h0, 4'h0, 1'b0);
        chk_state("R1", 4'hB, 4'h4, 1'b0, 1'b0);
        chk("R1", "reg_e", reg_e, 8'h4B);

        // R8: skip is a single-cycle pulse
        issue(4'd11, 4'h0, 4'hB, 1'b1);
        chk("R8", "skip pulse", {7'd0, skip}, 8'd1);
        @(negedge clk);
        chk("R8", "skip drop", {7'd0, skip}, 8'd0);

        // R2: all-maximum carry add: A=B+4=F, CY=1, then F+F+1
        issue(4'd8, 4'h0, 4'h0, 1'b1);
        issue(4'd2, 4'h0, 4'hB, 1'b1);
        chk_state("R3", 4'hF, 4'h4, 1'b0, 1'b0);
        issue(4'd5, 4'h0, 4'h0, 1'b1);
        issue(4'd1, 4'hF, 4'h0, 1'b1);
        chk_state("R2", 4'hF, 4'h4, 1'b1, 1'b0);

        // R8: mismatch keeps CY=1, no skip
        issue(4'd11, 4'h0, 4'h0, 1'b1);
        chk_state("R8", 4'hF, 4'h4, 1'b1, 1'b0);

        // R9: mid-run reset clears A, B, CY but E is kept
        issue(4'd9, 4'h0, 4'h0, 1'b1);
        chk("R7", "reg_e", reg_e, 8'h4F);
        rst_n = 1'b0;
        @(negedge clk);
        chk_state("R9", 4'h0, 4'h0, 1'b0, 1'b0);
        chk("R9", "reg_e kept", reg_e, 8'h4F);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule